// File: doc/BRIEF.md
# Row-Pair Readout and Binning Sequencer

This block drives the row-side controls of a pixel array whose rows are wired in pairs to dual-input column converters. Row `2p` (even) connects to the even input and row `2p+1` (odd) to the odd input of the converters in the same column. Rows are numbered from 0, and `p` is the pair index. For every output line, called a row slot, the sequencer drives the following:

- the even and odd select lines, with the pair index each select addresses;
- the switch that ties the two input sample capacitors in parallel. It is closed for single-row reads and open when two rows are averaged;
- a fixed sampling sequence: the signal-level strobe, then a pixel reset pulse, then the reset-level strobe, after which the row is released.

Three readout modes are chosen per frame. Normal mode reads every row alone. Binning mode reads both rows of a pair together, so the converter averages them. Shifted binning moves the pairing down by one row, so that butted tiles keep a uniform pitch. In that mode the first and the last row are each read alone, and the rows in between are paired across pair boundaries.

A frame is requested with a one-cycle `frame_go` while the sequencer is idle. The mode and row count are captured at that moment. Before each row slot the sequencer waits for the conversion timing to assert `line_rdy`. This is the only back-pressure point. While `line_rdy` is low between slots, every select, switch and strobe stays low, and nothing is lost: the slot simply starts later. A slot, once started, runs to completion regardless of `line_rdy`. The row count must be even and at least 2; its least significant bit is ignored. The phase lengths `T_SET`, `T_SHS`, `T_RST` and `T_SHR` must each be at least 1.

Top module: `rp_row_pair_seq`

## Requirements
- R1: Mode code 0 (normal) yields `num_rows` slots in row order. For each pair, the even row (`sel_even` only, `even_pair`=p) comes first, then the odd row (`sel_odd` only, `odd_pair`=p). `nobin_sw` is 1 in both.
- R2: Mode code 1 (binning) yields `num_rows/2` slots. Slot p raises both selects, with `even_pair`=`odd_pair`=p and `nobin_sw`=0.
- R3: Mode code 2 (shifted binning) yields `num_rows/2+1` slots, as follows:
  - The first slot raises only `sel_even` with pair 0, and `nobin_sw`=1.
  - Slot k, for k from 1 to `num_rows/2-1`, raises both selects with `odd_pair`=k-1, `even_pair`=k, and `nobin_sw`=0.
  - The last slot raises only `sel_odd` with pair `num_rows/2-1`, and `nobin_sw`=1.
- R4: A slot begins with a one-cycle `line_start` in which the selects are already raised. The selects stay unchanged for `T_SET` more cycles, then `shs` for `T_SHS` cycles, then `row_rst` for `T_RST` cycles, then `shr` for `T_SHR` cycles. After that the selects drop.
- R5: A slot's `line_start` appears only in the cycle after one in which the sequencer was waiting and sampled `line_rdy` high. Outside a slot, all selects, `nobin_sw`, `shs`, `row_rst` and `shr` are 0. Pair address fields are 0 whenever their select is low.
- R6: An accepted `frame_go` produces exactly one one-cycle `frame_start` in the following cycle, and it precedes the first `line_start`.
- R7: `frame_end` rises in the cycle right after the last cycle of the last slot and is 0 before that. It is held until the next accepted `frame_go`, which clears it in the cycle `frame_start` appears.
- R8: `mode_sel` and `num_rows` are sampled only when `frame_go` is accepted while idle. Changes to them, and any `frame_go`, during a frame have no effect on that frame.
- R9: During and right after reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_go | input | 1 | Frame request, accepted only while idle |
| mode_sel | input | 2 | 0 normal, 1 binning, 2 shifted binning, 3 treated as normal |
| num_rows | input | ROW_W | Rows in the array (even, at least 2) |
| line_rdy | input | 1 | Conversion timing ready for the next row slot |
| frame_start | output | 1 | One-cycle pulse ahead of the first slot |
| line_start | output | 1 | One-cycle pulse opening each row slot |
| sel_even | output | 1 | Even-row select |
| sel_odd | output | 1 | Odd-row select |
| nobin_sw | output | 1 | Parallel (no averaging) switch closed |
| even_pair | output | ROW_W-1 | Pair index addressed by the even select |
| odd_pair | output | ROW_W-1 | Pair index addressed by the odd select |
| shs | output | 1 | Signal-level sampling strobe |
| row_rst | output | 1 | Pixel reset pulse for the selected rows |
| shr | output | 1 | Reset-level sampling strobe |
| frame_end | output | 1 | Frame complete, held until the next frame |

## Verification
The hardest situation to reach from the ports is a change of `mode_sel` and `num_rows` together with a fresh `frame_go` while a shifted-binning frame is already running. Only the scoreboard's slot list reveals whether the frame silently switched geometry. The stimulus starts that frame, waits until several slots have gone by, then drives a different mode and row count and pulses `frame_go`. It then expects the original edge slots and the original slot count. Back-pressure is reached by holding `line_rdy` low for a long stretch and by a sparse ready pattern, so that slots start after gaps of varying length.

// File: rtl/rp_pkg.sv
package rp_pkg;

  typedef enum logic [1:0] {
    RM_NORMAL = 2'd0,
    RM_BIN    = 2'd1,
    RM_SHIFT  = 2'd2
  } rd_mode_e;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_LS   = 3'd1,
    PH_SET  = 3'd2,
    PH_SHS  = 3'd3,
    PH_RST  = 3'd4,
    PH_SHR  = 3'd5
  } phase_e;

  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_HEAD = 2'd1,
    FS_WAIT = 2'd2,
    FS_BUSY = 2'd3
  } fstate_e;

  // Unused code 3 falls back to single-row readout.
  function automatic rd_mode_e decode_mode(input logic [1:0] code);
    case (code)
      2'd1:    decode_mode = RM_BIN;
      2'd2:    decode_mode = RM_SHIFT;
      default: decode_mode = RM_NORMAL;
    endcase
  endfunction

endpackage

// File: rtl/rp_phase_timer.sv
module rp_phase_timer
  import rp_pkg::*;
#(
  parameter int T_SET = 2,
  parameter int T_SHS = 3,
  parameter int T_RST = 2,
  parameter int T_SHR = 3
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  output phase_e phase,
  output logic   done
);

  localparam int T_MAX01 = (T_SET > T_SHS) ? T_SET : T_SHS;
  localparam int T_MAX23 = (T_RST > T_SHR) ? T_RST : T_SHR;
  localparam int T_MAX   = (T_MAX01 > T_MAX23) ? T_MAX01 : T_MAX23;
  localparam int CNT_W   = (T_MAX > 1) ? $clog2(T_MAX) : 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last_cnt;

  always_comb begin
    case (phase)
      PH_SET:  last_cnt = CNT_W'(T_SET - 1);
      PH_SHS:  last_cnt = CNT_W'(T_SHS - 1);
      PH_RST:  last_cnt = CNT_W'(T_RST - 1);
      PH_SHR:  last_cnt = CNT_W'(T_SHR - 1);
      default: last_cnt = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else begin
      case (phase)
        PH_IDLE: begin
          if (start) phase <= PH_LS;
          cnt <= '0;
        end
        PH_LS: begin
          phase <= PH_SET;
          cnt   <= '0;
        end
        default: begin
          if (cnt == last_cnt) begin
            cnt <= '0;
            case (phase)
              PH_SET:  phase <= PH_SHS;
              PH_SHS:  phase <= PH_RST;
              PH_RST:  phase <= PH_SHR;
              default: phase <= PH_IDLE;
            endcase
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      endcase
    end
  end

  assign done = (phase == PH_SHR) && (cnt == last_cnt);

  AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> phase == PH_IDLE); // R5

  AST_SHR_AFTER_RST: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_SHR && $past(phase) != PH_SHR) |-> $past(phase) == PH_RST); // R4

  AST_SHS_AFTER_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_SHS && $past(phase) != PH_SHS) |-> $past(phase) == PH_SET); // R4

endmodule

// File: rtl/rp_slot_map.sv
module rp_slot_map
  import rp_pkg::*;
#(
  parameter int ROW_W      = 10,
  parameter bit EVEN_FIRST = 1'b1,
  localparam int PAIR_W    = ROW_W - 1
) (
  input  rd_mode_e          mode,
  input  logic [ROW_W-1:0]  slot,
  input  logic [PAIR_W-1:0] npairs,
  output logic              sel_even,
  output logic              sel_odd,
  output logic              nobin,
  output logic [PAIR_W-1:0] even_pair,
  output logic [PAIR_W-1:0] odd_pair,
  output logic              last_slot
);

  logic [PAIR_W-1:0] slot_lo;
  logic [PAIR_W-1:0] slot_half;
  logic              slot_par;
  logic              norm_even;

  assign slot_lo   = slot[PAIR_W-1:0];
  assign slot_half = slot[ROW_W-1:1];
  assign slot_par  = slot[0];

  // Order of the two rows of a pair in normal mode.
  generate
    if (EVEN_FIRST) begin : g_even_first
      assign norm_even = ~slot_par;
    end else begin : g_odd_first
      assign norm_even = slot_par;
    end
  endgenerate

  always_comb begin
    sel_even  = 1'b0;
    sel_odd   = 1'b0;
    nobin     = 1'b1;
    even_pair = '0;
    odd_pair  = '0;
    last_slot = 1'b0;
    case (mode)
      RM_BIN: begin
        sel_even  = 1'b1;
        sel_odd   = 1'b1;
        nobin     = 1'b0;
        even_pair = slot_lo;
        odd_pair  = slot_lo;
        last_slot = (slot == ({1'b0, npairs} - 1'b1));
      end
      RM_SHIFT: begin
        last_slot = (slot == {1'b0, npairs});
        if (slot == '0) begin
          sel_even = 1'b1;
        end else if (last_slot) begin
          sel_odd  = 1'b1;
          odd_pair = npairs - 1'b1;
        end else begin
          sel_even  = 1'b1;
          sel_odd   = 1'b1;
          nobin     = 1'b0;
          even_pair = slot_lo;
          odd_pair  = slot_lo - 1'b1;
        end
      end
      default: begin
        last_slot = (slot == {npairs - 1'b1, 1'b1});
        if (norm_even) begin
          sel_even  = 1'b1;
          even_pair = slot_half;
        end else begin
          sel_odd  = 1'b1;
          odd_pair = slot_half;
        end
      end
    endcase
  end

endmodule

// File: rtl/rp_frame_ctl.sv
module rp_frame_ctl
  import rp_pkg::*;
#(
  parameter int ROW_W   = 10,
  localparam int PAIR_W = ROW_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_go,
  input  logic [1:0]        mode_in,
  input  logic [ROW_W-1:0]  rows_in,
  input  logic              line_rdy,
  input  logic              tmr_done,
  input  logic              last_slot,
  output rd_mode_e          mode_q,
  output logic [PAIR_W-1:0] npairs_q,
  output logic [ROW_W-1:0]  slot,
  output logic              tmr_start,
  output logic              frame_start,
  output logic              frame_end
);

  fstate_e state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= FS_IDLE;
      mode_q    <= RM_NORMAL;
      npairs_q  <= '0;
      slot      <= '0;
      frame_end <= 1'b0;
    end else begin
      case (state)
        FS_IDLE: begin
          if (frame_go) begin
            mode_q    <= decode_mode(mode_in);
            npairs_q  <= rows_in[ROW_W-1:1];
            slot      <= '0;
            frame_end <= 1'b0;
            state     <= FS_HEAD;
          end
        end
        FS_HEAD: state <= FS_WAIT;
        FS_WAIT: if (line_rdy) state <= FS_BUSY;
        default: begin
          if (tmr_done) begin
            if (last_slot) begin
              frame_end <= 1'b1;
              state     <= FS_IDLE;
            end else begin
              slot  <= slot + 1'b1;
              state <= FS_WAIT;
            end
          end
        end
      endcase
    end
  end

  assign tmr_start   = (state == FS_WAIT) && line_rdy;
  assign frame_start = (state == FS_HEAD);

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (state != FS_IDLE && $past(state) != FS_IDLE) |-> ($stable(mode_q) && $stable(npairs_q))); // R8

  AST_FEND_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && !(state == FS_IDLE && frame_go)) |=> frame_end); // R7

  AST_DONE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_done |-> state == FS_BUSY); // R4

endmodule

// File: rtl/rp_row_pair_seq.sv
module rp_row_pair_seq
  import rp_pkg::*;
#(
  parameter int ROW_W      = 10,
  parameter bit EVEN_FIRST = 1'b1,
  parameter int T_SET      = 2,
  parameter int T_SHS      = 3,
  parameter int T_RST      = 2,
  parameter int T_SHR      = 3,
  localparam int PAIR_W    = ROW_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_go,
  input  logic [1:0]        mode_sel,
  input  logic [ROW_W-1:0]  num_rows,
  input  logic              line_rdy,
  output logic              frame_start,
  output logic              line_start,
  output logic              sel_even,
  output logic              sel_odd,
  output logic              nobin_sw,
  output logic [PAIR_W-1:0] even_pair,
  output logic [PAIR_W-1:0] odd_pair,
  output logic              shs,
  output logic              row_rst,
  output logic              shr,
  output logic              frame_end
);

  rd_mode_e          mode_q;
  logic [PAIR_W-1:0] npairs_q;
  logic [ROW_W-1:0]  slot;
  logic              tmr_start;
  logic              tmr_done;
  logic              last_slot;
  phase_e            phase;
  logic              active;

  logic              m_even, m_odd, m_nobin;
  logic [PAIR_W-1:0] m_even_pair, m_odd_pair;

  rp_frame_ctl #(.ROW_W(ROW_W)) u_frame (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_go    (frame_go),
    .mode_in     (mode_sel),
    .rows_in     (num_rows),
    .line_rdy    (line_rdy),
    .tmr_done    (tmr_done),
    .last_slot   (last_slot),
    .mode_q      (mode_q),
    .npairs_q    (npairs_q),
    .slot        (slot),
    .tmr_start   (tmr_start),
    .frame_start (frame_start),
    .frame_end   (frame_end)
  );

  rp_phase_timer #(
    .T_SET (T_SET),
    .T_SHS (T_SHS),
    .T_RST (T_RST),
    .T_SHR (T_SHR)
  ) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (tmr_start),
    .phase (phase),
    .done  (tmr_done)
  );

  rp_slot_map #(.ROW_W(ROW_W), .EVEN_FIRST(EVEN_FIRST)) u_map (
    .mode      (mode_q),
    .slot      (slot),
    .npairs    (npairs_q),
    .sel_even  (m_even),
    .sel_odd   (m_odd),
    .nobin     (m_nobin),
    .even_pair (m_even_pair),
    .odd_pair  (m_odd_pair),
    .last_slot (last_slot)
  );

  assign active     = (phase != PH_IDLE);
  assign line_start = (phase == PH_LS);
  assign shs        = (phase == PH_SHS);
  assign row_rst    = (phase == PH_RST);
  assign shr        = (phase == PH_SHR);
  assign sel_even   = active & m_even;
  assign sel_odd    = active & m_odd;
  assign nobin_sw   = active & m_nobin;
  assign even_pair  = (active & m_even) ? m_even_pair : '0;
  assign odd_pair   = (active & m_odd)  ? m_odd_pair  : '0;

  AST_NORMAL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == RM_NORMAL) |-> !(sel_even && sel_odd)); // R1

  AST_BIN_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == RM_BIN && line_start) |-> (sel_even && sel_odd && !nobin_sw)); // R2

  AST_SHIFT_FIRST_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == RM_SHIFT && line_start && slot == '0) |-> (sel_even && !sel_odd && nobin_sw)); // R3

  AST_STROBE_UNDER_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    (shs || row_rst || shr) |-> (sel_even || sel_odd)); // R4

  AST_SEL_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active) && !line_start) |-> ($stable(sel_even) && $stable(sel_odd) && $stable(even_pair) && $stable(odd_pair))); // R4

  AST_LINE_AFTER_RDY: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |-> $past(line_rdy)); // R5

  AST_FSTART_NO_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> !active); // R6

endmodule

// File: tb/test_rp_row_pair_seq.sv
module test_rp_row_pair_seq;

  localparam int ROW_W  = 10;
  localparam int PAIR_W = ROW_W - 1;
  localparam int T_SET  = 2;
  localparam int T_SHS  = 3;
  localparam int T_RST  = 2;
  localparam int T_SHR  = 3;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              frame_go = 1'b0;
  logic [1:0]        mode_sel = 2'd0;
  logic [ROW_W-1:0]  num_rows = '0;
  logic              line_rdy = 1'b0;
  logic              frame_start, line_start, sel_even, sel_odd, nobin_sw;
  logic [PAIR_W-1:0] even_pair, odd_pair;
  logic              shs, row_rst, shr, frame_end;

  always #10 clk = ~clk;

  rp_row_pair_seq #(
    .ROW_W(ROW_W), .T_SET(T_SET), .T_SHS(T_SHS), .T_RST(T_RST), .T_SHR(T_SHR)
  ) i_rp_row_pair_seq (
    .clk(clk), .rst_n(rst_n), .frame_go(frame_go), .mode_sel(mode_sel),
    .num_rows(num_rows), .line_rdy(line_rdy), .frame_start(frame_start),
    .line_start(line_start), .sel_even(sel_even), .sel_odd(sel_odd),
    .nobin_sw(nobin_sw), .even_pair(even_pair), .odd_pair(odd_pair),
    .shs(shs), .row_rst(row_rst), .shr(shr), .frame_end(frame_end)
  );

  int checks = 0;
  int errs   = 0;

  logic [2*PAIR_W+2:0] exp_q[$];
  string               cur_tag = "R1";

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic logic [2*PAIR_W+2:0] pk(input bit se, input bit so, input bit nb,
                                              input int ep, input int op);
    return {se, so, nb, PAIR_W'(ep), PAIR_W'(op)};
  endfunction

  // Ready pattern: 0 always ready, 1 sparse; rdy_block forces not ready.
  int  rdy_pat   = 0;
  bit  rdy_block = 1'b1;
  int  cyc       = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    line_rdy <= !rdy_block && (rdy_pat == 0 || (cyc % 3) == 0);
  end

  // Monitor / scoreboard
  bit  prev_rdy = 1'b0;
  bit  in_slot  = 1'b0;
  int  fs_cnt   = 0;
  int  ln_cnt   = 0;
  int  shs_n, rst_n_cnt, shr_n;
  logic [2*PAIR_W+2:0] cur;

  always @(negedge clk) begin
    if (rst_n) begin
      logic [2*PAIR_W+2:0] act;
      act = {sel_even, sel_odd, nobin_sw, even_pair, odd_pair};
      if (frame_start) fs_cnt++;
      if (line_start) begin
        ln_cnt++;
        chk(prev_rdy, "R5", "line_start without prior ready", 0, 1);
        chk(fs_cnt == 1, "R6", "frame_start seen before line", fs_cnt, 1);
        if (exp_q.size() == 0) begin
          chk(1'b0, cur_tag, "unexpected slot", act, 0);
        end else begin
          logic [2*PAIR_W+2:0] e;
          e = exp_q.pop_front();
          chk(act == e, cur_tag, "slot controls", act, e);
        end
        cur = act; in_slot = 1'b1; shs_n = 0; rst_n_cnt = 0; shr_n = 0;
      end else if (in_slot) begin
        if (!sel_even && !sel_odd) begin
          chk(shs_n == T_SHS, "R4", "shs length", shs_n, T_SHS);
          chk(rst_n_cnt == T_RST, "R4", "row_rst length", rst_n_cnt, T_RST);
          chk(shr_n == T_SHR, "R4", "shr length", shr_n, T_SHR);
          chk(frame_end == (exp_q.size() == 0), "R7", "frame_end at slot end",
              frame_end, exp_q.size() == 0);
          in_slot = 1'b0;
        end else begin
          if (act != cur) chk(1'b0, "R4", "select changed in slot", act, cur);
          if (shs) begin
            if (rst_n_cnt != 0 || shr_n != 0) chk(1'b0, "R4", "shs after reset", rst_n_cnt, 0);
            shs_n++;
          end
          if (row_rst) begin
            if (shs_n != T_SHS || shr_n != 0) chk(1'b0, "R4", "reset before shs done", shs_n, T_SHS);
            rst_n_cnt++;
          end
          if (shr) begin
            if (rst_n_cnt != T_RST) chk(1'b0, "R4", "shr before reset done", rst_n_cnt, T_RST);
            shr_n++;
          end
        end
      end
      if (!in_slot && !line_start &&
          (sel_even || sel_odd || nobin_sw || shs || row_rst || shr || even_pair != 0 || odd_pair != 0))
        chk(1'b0, "R5", "controls active outside slot", act, 0);
    end
    prev_rdy = line_rdy;
  end

  task automatic push_frame(input int m, input int n);
    int p;
    p = n / 2;
    if (m == 1) begin
      for (int k = 0; k < p; k++) exp_q.push_back(pk(1, 1, 0, k, k));
    end else if (m == 2) begin
      exp_q.push_back(pk(1, 0, 1, 0, 0));
      for (int k = 1; k < p; k++) exp_q.push_back(pk(1, 1, 0, k, k - 1));
      exp_q.push_back(pk(0, 1, 1, 0, p - 1));
    end else begin
      for (int r = 0; r < n; r++)
        if (r % 2 == 0) exp_q.push_back(pk(1, 0, 1, r / 2, 0));
        else            exp_q.push_back(pk(0, 1, 1, 0, r / 2));
    end
  endtask

  task automatic start_frame(input int m, input int n, input string tag);
    cur_tag = tag;
    push_frame(m, n);
    @(posedge clk);
    fs_cnt   <= 0;
    ln_cnt   <= 0;
    mode_sel <= 2'(m);
    num_rows <= ROW_W'(n);
    frame_go <= 1'b1;
    @(posedge clk);
    frame_go <= 1'b0;
    @(negedge clk);
    chk(frame_start == 1'b1, "R6", "frame_start after go", frame_start, 1);
    chk(frame_end == 1'b0, "R7", "frame_end cleared", frame_end, 0);
    chk(line_start == 1'b0, "R6", "no line with frame_start", line_start, 0);
  endtask

  task automatic finish_frame(input int nslots, input string tag);
    while (!frame_end) @(negedge clk);
    chk(exp_q.size() == 0, tag, "slots left over", exp_q.size(), 0);
    chk(ln_cnt == nslots, tag, "line count", ln_cnt, nslots);
    chk(fs_cnt == 1, "R6", "frame_start count", fs_cnt, 1);
    repeat (5) @(negedge clk);
    chk(frame_end == 1'b1, "R7", "frame_end held", frame_end, 1);
    exp_q.delete();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errs++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    // R9: reset values
    repeat (3) @(negedge clk);
    chk({frame_start, line_start, sel_even, sel_odd, nobin_sw, shs, row_rst, shr, frame_end} == 0,
        "R9", "outputs in reset", 0, 0);
    @(posedge clk); rst_n <= 1'b1;
    @(negedge clk);
    chk({frame_start, line_start, sel_even, sel_odd, nobin_sw, even_pair, odd_pair, frame_end} == 0,
        "R9", "outputs after reset", 0, 0);
    rdy_block = 1'b0;

    // R1: normal readout, always ready
    rdy_pat = 0;
    start_frame(0, 6, "R1");
    finish_frame(6, "R1");

    // R2: binning with sparse ready pattern
    rdy_pat = 1;
    start_frame(1, 8, "R2");
    finish_frame(4, "R2");

    // R3 + R8: shifted binning, config changed and go repeated mid-frame
    rdy_pat = 0;
    start_frame(2, 8, "R3");
    repeat (30) @(posedge clk);
    mode_sel <= 2'd0; num_rows <= ROW_W'(20); frame_go <= 1'b1;
    @(posedge clk); frame_go <= 1'b0;
    @(negedge clk);
    chk(frame_start == 1'b0, "R8", "go ignored mid-frame", frame_start, 0);
    finish_frame(5, "R3");

    // R3 edge: two rows only
    start_frame(2, 2, "R3");
    finish_frame(2, "R3");

    // R5: long back-pressure before first slot
    rdy_block = 1'b1;
    start_frame(1, 4, "R5");
    repeat (30) @(negedge clk);
    chk(ln_cnt == 0, "R5", "no slot while not ready", ln_cnt, 0);
    rdy_block = 1'b0;
    finish_frame(2, "R5");

    // Mode code 3 runs as normal readout
    rdy_pat = 1;
    start_frame(3, 4, "R1");
    finish_frame(4, "R1");

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule